// File: doc/BRIEF.md
# Sector Reader Host-Side Bus Slave

This block is the host-facing slave of a disk sector reader. A host master uses a single 16-bit data path and one address bit to do three things. It loads a 28-bit logical block address in two halves. It fetches sector words one at a time. It observes a word-available tag and an error flag. The block does not talk to the card itself. On its far side it hands the block address to a sector read controller and asks that controller for one word per read strobe. When the controller reports a failure, it asks the controller to reset the card.

A write strobe updates half of the block address and tells the controller to drop any buffered sector. It is acknowledged at once, with no disk activity. A read strobe is acknowledged only after a word has arrived from the controller. If the controller flags an error on that word, the block first raises the error output. It then requests a card reset and repeats the same word request, and the master sees nothing but a longer wait. The acknowledge ends on its own after a fixed number of cycles, or one cycle after the master removes the strobe. A strobe that stays high is never taken as a second request.

Top module: `sr_wb_front`

## Requirements
- R1: A write strobe (`stb_i`=1, `we_i`=1) with `adr_i`=0 copies `dat_i[15:0]` into `lba_o[15:0]` at the accepting edge and leaves `lba_o[27:16]` unchanged.
- R2: A write strobe with `adr_i`=1 copies `dat_i[7:0]` into `lba_o[23:16]` and `dat_i[11:8]` into `lba_o[27:24]`. `dat_i[15:12]` is ignored and `lba_o[15:0]` is unchanged.
- R3: Every address write produces a one-cycle `lba_clr_o` pulse in the cycle after acceptance. In that same cycle `ack_o`=1, `word_req_o`=0 and `drive_en_o`=0.
- R4: A read strobe (`stb_i`=1, `we_i`=0) raises `word_req_o` in the cycle after acceptance and holds it until `word_vld_i` is seen. `ack_o` stays 0 throughout.
- R5: When `word_vld_i`=1 with `word_err_i`=0, the next cycle shows `dat_o` equal to `word_dat_i`, `word_tag_o`=1, `ack_o`=1 and `drive_en_o`=1.
- R6: When `word_vld_i`=1 with `word_err_i`=1, the next cycle shows `err_o`=1, `reset_req_o`=1, `word_req_o`=0 and `ack_o`=0. On `reset_done_i`=1 the next cycle shows `word_req_o`=1 again and `err_o`=0.
- R7: With the strobe held, `ack_o` stays high for exactly ACK_CYCLES cycles (default 4) and then drops by itself.
- R8: If `stb_i` is 0 while `ack_o` is 1, both `ack_o` and `drive_en_o` are 0 in the next cycle.
- R9: A strobe held high after its acknowledge starts no new transaction. A new request is accepted only after `stb_i` has been sampled low.
- R10: After reset, `ack_o`, `drive_en_o`, `word_req_o`, `reset_req_o`, `lba_clr_o`, `word_tag_o` and `err_o` are 0, and `lba_o` is 0.
- R11: `word_tag_o` stays 1 after a word capture and returns to 0 in the cycle after the next strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb_i | input | 1 | Host strobe |
| we_i | input | 1 | Host write enable |
| adr_i | input | 1 | Address bit: 0 low address half, 1 high half |
| dat_i | input | 16 | Host write data |
| dat_o | output | 16 | Fetched word for the host |
| ack_o | output | 1 | Acknowledge to host |
| drive_en_o | output | 1 | Enables the host data drivers during a read response |
| word_tag_o | output | 1 | A word has been captured from the card |
| err_o | output | 1 | Controller reported an error on the current fetch |
| lba_o | output | 28 | Logical block address for the controller |
| lba_clr_o | output | 1 | Pulse: discard buffered sector state |
| word_req_o | output | 1 | Request one word from the controller |
| word_vld_i | input | 1 | Controller returns a word (one-cycle pulse) |
| word_err_i | input | 1 | Qualifies `word_vld_i`: the fetch failed |
| word_dat_i | input | 16 | Word from the controller |
| reset_req_o | output | 1 | Ask the controller to reset the card |
| reset_done_i | input | 1 | Controller finished the card reset (pulse) |

## Verification
The hardest case to reach from the ports is a retry. Here a failed word must be followed by a card reset and a fresh request, with no acknowledge leaking out and the error flag going up and then down at the right edges. The bench plays the controller itself. It answers the first request with an error-qualified pulse and waits several cycles before reporting reset completion, then checks each of these steps before supplying a clean word. A second hard case is a master that keeps its strobe high. The bench holds it through the entire acknowledge window and beyond, counting acknowledge cycles and watching for spurious requests, before it lowers the strobe and raises it again.

// File: rtl/sr_fe_pkg.sv
package sr_fe_pkg;

  localparam int WORD_W = 16;
  localparam int LBA_W  = 28;

  typedef enum logic [2:0] {
    FE_IDLE,
    FE_FETCH,
    FE_RESET,
    FE_ACK,
    FE_HOLD
  } fe_state_e;

  // Merge one host write into the stored block address.
  // hi_sel=0: word lands in [15:0]. hi_sel=1: low byte to [23:16],
  // low nibble of the high byte to [27:24], top nibble dropped.
  function automatic logic [LBA_W-1:0] lba_merge(
    input logic [LBA_W-1:0]  cur,
    input logic              hi_sel,
    input logic [WORD_W-1:0] wd
  );
    logic [LBA_W-1:0] nxt;
    nxt = cur;
    if (hi_sel) begin
      nxt[23:16] = wd[7:0];
      nxt[27:24] = wd[11:8];
    end else begin
      nxt[15:0] = wd;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/sr_fe_lba_regs.sv
module sr_fe_lba_regs
  import sr_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              hi_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [LBA_W-1:0]  lba_o
);

  logic [LBA_W-1:0] lba_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lba_q <= '0;
    end else if (wr_en) begin
      lba_q <= lba_merge(lba_q, hi_sel, wdata);
    end
  end

  assign lba_o = lba_q;

  AST_LBA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lba_o)); // R1

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hi_sel |=> lba_o[15:0] == $past(lba_o[15:0])); // R2

  AST_LO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !hi_sel |=> lba_o[27:16] == $past(lba_o[27:16])); // R1

endmodule

// File: rtl/sr_fe_ack_timer.sv
module sr_fe_ack_timer #(
  parameter int ACK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CNT_W = $clog2(ACK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ACK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (!expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R7

  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0); // R7

endmodule

// File: rtl/sr_fe_rd_capture.sv
module sr_fe_rd_capture
  import sr_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] cap_data,
  input  logic              tag_clr,
  input  logic              err_set,
  input  logic              err_clr,
  output logic [WORD_W-1:0] dat_o,
  output logic              tag_o,
  output logic              err_o
);

  logic [WORD_W-1:0] dat_q;
  logic              tag_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= '0;
      tag_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (cap_en) begin
        dat_q <= cap_data;
        tag_q <= 1'b1;
      end else if (tag_clr) begin
        tag_q <= 1'b0;
      end
      if (err_set) begin
        err_q <= 1'b1;
      end else if (err_clr) begin
        err_q <= 1'b0;
      end
    end
  end

  assign dat_o = dat_q;
  assign tag_o = tag_q;
  assign err_o = err_q;

  AST_TAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> tag_o && (dat_o == $past(cap_data))); // R5

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_o); // R6

  AST_TAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tag_clr && !cap_en |=> !tag_o); // R11

endmodule

// File: rtl/sr_wb_front.sv
module sr_wb_front
  import sr_fe_pkg::*;
#(
  parameter int ACK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic              adr_i,
  input  logic [WORD_W-1:0] dat_i,
  output logic [WORD_W-1:0] dat_o,
  output logic              ack_o,
  output logic              drive_en_o,
  output logic              word_tag_o,
  output logic              err_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic              lba_clr_o,
  output logic              word_req_o,
  input  logic              word_vld_i,
  input  logic              word_err_i,
  input  logic [WORD_W-1:0] word_dat_i,
  output logic              reset_req_o,
  input  logic              reset_done_i
);

  fe_state_e state_q, state_d;
  logic      is_rd_q;
  logic      clr_q;

  // Named internal events
  logic acc_any;
  logic acc_wr;
  logic acc_rd;
  logic word_ok;
  logic word_bad;
  logic retry_go;
  logic ack_expire;
  logic in_ack;

  assign acc_any  = (state_q == FE_IDLE) && stb_i;
  assign acc_wr   = acc_any && we_i;
  assign acc_rd   = acc_any && !we_i;
  assign word_ok  = (state_q == FE_FETCH) && word_vld_i && !word_err_i;
  assign word_bad = (state_q == FE_FETCH) && word_vld_i && word_err_i;
  assign retry_go = (state_q == FE_RESET) && reset_done_i;
  assign in_ack   = (state_q == FE_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FE_IDLE: begin
        if (acc_wr)      state_d = FE_ACK;
        else if (acc_rd) state_d = FE_FETCH;
      end
      FE_FETCH: begin
        if (word_bad)     state_d = FE_RESET;
        else if (word_ok) state_d = FE_ACK;
      end
      FE_RESET: begin
        if (retry_go) state_d = FE_FETCH;
      end
      FE_ACK: begin
        if (!stb_i)          state_d = FE_IDLE;
        else if (ack_expire) state_d = FE_HOLD;
      end
      FE_HOLD: begin
        if (!stb_i) state_d = FE_IDLE;
      end
      default: state_d = FE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FE_IDLE;
      is_rd_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= acc_wr;
      if (acc_any) is_rd_q <= !we_i;
    end
  end

  sr_fe_lba_regs u_lba (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (acc_wr),
    .hi_sel (adr_i),
    .wdata  (dat_i),
    .lba_o  (lba_o)
  );

  sr_fe_ack_timer #(
    .ACK_CYCLES (ACK_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_ack),
    .expire (ack_expire)
  );

  sr_fe_rd_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (word_ok),
    .cap_data (word_dat_i),
    .tag_clr  (acc_any),
    .err_set  (word_bad),
    .err_clr  (retry_go),
    .dat_o    (dat_o),
    .tag_o    (word_tag_o),
    .err_o    (err_o)
  );

  assign ack_o       = in_ack;
  assign drive_en_o  = in_ack && is_rd_q;
  assign word_req_o  = (state_q == FE_FETCH);
  assign reset_req_o = (state_q == FE_RESET);
  assign lba_clr_o   = clr_q;

  AST_REQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    word_req_o |-> !ack_o); // R4

  AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> !word_req_o && !ack_o); // R6

  AST_DRIVE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o |-> ack_o && word_tag_o); // R5

  AST_CLR_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    lba_clr_o |-> ack_o && !drive_en_o && !word_req_o); // R3

  AST_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && !stb_i |=> !ack_o && !drive_en_o); // R8

  AST_RETRY_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o && reset_done_i |=> word_req_o && !err_o); // R6

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !word_req_o); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    word_req_o && !word_vld_i |=> word_req_o); // R4

endmodule

// File: tb/tb_sr_wb_front.sv
module tb_sr_wb_front;
  import sr_fe_pkg::*;

  localparam int ACKN = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              stb_i, we_i, adr_i;
  logic [WORD_W-1:0] dat_i;
  logic [WORD_W-1:0] dat_o;
  logic              ack_o, drive_en_o, word_tag_o, err_o;
  logic [LBA_W-1:0]  lba_o;
  logic              lba_clr_o, word_req_o;
  logic              word_vld_i, word_err_i;
  logic [WORD_W-1:0] word_dat_i;
  logic              reset_req_o, reset_done_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [27:0] exp_lba = '0;

  always #10 clk = ~clk;

  sr_wb_front #(.ACK_CYCLES(ACKN)) dut (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i),
    .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o), .drive_en_o(drive_en_o),
    .word_tag_o(word_tag_o), .err_o(err_o), .lba_o(lba_o),
    .lba_clr_o(lba_clr_o), .word_req_o(word_req_o), .word_vld_i(word_vld_i),
    .word_err_i(word_err_i), .word_dat_i(word_dat_i),
    .reset_req_o(reset_req_o), .reset_done_i(reset_done_i)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stb_i = 0; we_i = 0; adr_i = 0; dat_i = '0;
    word_vld_i = 0; word_err_i = 0; word_dat_i = '0; reset_done_i = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk({ack_o, drive_en_o, word_req_o, reset_req_o, lba_clr_o, word_tag_o, err_o} == 7'b0,
        "R10 control outputs after reset",
        32'({ack_o, drive_en_o, word_req_o, reset_req_o, lba_clr_o, word_tag_o, err_o}), 0);
    chk(lba_o == '0, "R10 lba after reset", 32'(lba_o), 0);
  endtask

  task automatic t_lba_write(input logic a, input logic [15:0] d, input string tag);
    stb_i = 1; we_i = 1; adr_i = a; dat_i = d;
    if (a) begin
      exp_lba[23:16] = d[7:0];
      exp_lba[27:24] = d[11:8];
    end else begin
      exp_lba[15:0] = d;
    end
    step();
    chk(lba_o == exp_lba, {tag, " lba value"}, 32'(lba_o), 32'(exp_lba));
    chk(lba_clr_o && ack_o && !word_req_o && !drive_en_o,
        "R3 clear pulse with plain ack", 32'({lba_clr_o, ack_o, word_req_o, drive_en_o}), 32'b1100);
    stb_i = 0; we_i = 0;
    step();
    chk(!lba_clr_o && !ack_o, "R3/R8 pulse and ack end",
        32'({lba_clr_o, ack_o}), 0);
    chk(lba_o == exp_lba, {tag, " lba kept"}, 32'(lba_o), 32'(exp_lba));
  endtask

  task automatic issue_read(input int wait_n);
    stb_i = 1; we_i = 0;
    step();
    chk(word_req_o && !ack_o, "R4 request after accept", 32'({word_req_o, ack_o}), 32'b10);
    chk(!word_tag_o, "R11 tag cleared on accept", 32'(word_tag_o), 0);
    for (int i = 0; i < wait_n; i++) begin
      step();
      chk(word_req_o && !ack_o, "R4 request held", 32'({word_req_o, ack_o}), 32'b10);
    end
  endtask

  task automatic give_word(input logic [15:0] w);
    word_vld_i = 1; word_err_i = 0; word_dat_i = w;
    step();
    word_vld_i = 0;
    chk(ack_o && drive_en_o && word_tag_o && dat_o == w, "R5 word returned",
        32'({ack_o, drive_en_o, word_tag_o, dat_o}), 32'({3'b111, w}));
  endtask

  task automatic t_read_clean(input logic [15:0] w, input int wait_n);
    issue_read(wait_n);
    give_word(w);
    stb_i = 0;
    step();
    chk(!ack_o && !drive_en_o, "R8 release ends ack", 32'({ack_o, drive_en_o}), 0);
    chk(word_tag_o && dat_o == w, "R11 tag kept after ack", 32'({word_tag_o, dat_o}),
        32'({1'b1, w}));
  endtask

  task automatic t_read_retry(input logic [15:0] w);
    issue_read(1);
    word_vld_i = 1; word_err_i = 1; word_dat_i = 16'hDEAD;
    step();
    word_vld_i = 0; word_err_i = 0;
    chk(err_o && reset_req_o && !word_req_o && !ack_o, "R6 error enters reset",
        32'({err_o, reset_req_o, word_req_o, ack_o}), 32'b1100);
    repeat (3) step();
    chk(reset_req_o && !ack_o && err_o, "R6 reset held", 32'({reset_req_o, ack_o, err_o}), 32'b101);
    reset_done_i = 1;
    step();
    reset_done_i = 0;
    chk(word_req_o && !err_o && !reset_req_o, "R6 retry starts, error cleared",
        32'({word_req_o, err_o, reset_req_o}), 32'b100);
    give_word(w);
    stb_i = 0;
    step();
    chk(!ack_o, "R8 release after retry", 32'(ack_o), 0);
  endtask

  task automatic t_held_strobe(input logic [15:0] w1, input logic [15:0] w2);
    int acks = 0;
    int reqs = 0;
    issue_read(0);
    word_vld_i = 1; word_err_i = 0; word_dat_i = w1;
    step();
    word_vld_i = 0;
    for (int i = 0; i < 10; i++) begin
      if (ack_o) acks++;
      if (word_req_o) reqs++;
      step();
    end
    chk(acks == ACKN, "R7 ack length with strobe held", 32'(acks), 32'(ACKN));
    chk(reqs == 0 && !ack_o, "R9 no second transaction", 32'(reqs), 0);
    stb_i = 0;
    step();
    chk(!word_req_o && !ack_o, "R9 idle after release", 32'({word_req_o, ack_o}), 0);
    t_read_clean(w2, 2);
  endtask

  initial begin
    t_reset();
    t_lba_write(1'b0, 16'hA55A, "R1");
    chk(lba_o[27:16] == 12'h000, "R1 upper untouched", 32'(lba_o[27:16]), 0);
    t_lba_write(1'b1, 16'hF3C7, "R2");
    chk(lba_o[27:24] == 4'h3 && lba_o[15:0] == 16'hA55A, "R2 nibble and low kept",
        32'(lba_o), 32'h3C7A55A);
    t_lba_write(1'b0, 16'h0102, "R1");
    t_read_clean(16'h1234, 0);
    t_read_clean(16'hBEEF, 5);
    t_read_retry(16'h4321);
    t_held_strobe(16'h0F0F, 16'h7777);
    t_lba_write(1'b1, 16'h0A00, "R2");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule